// File: doc/BRIEF.md
# DTMF Tone Synthesizer with Burst Sequencer

This block turns a 4-bit dial digit into a digital dual-tone sample stream. Two channels of the same design, one for the low-group (row) tone and one for the high-group (column) tone, each run a programmable divider. Every time a divider reloads it advances a 32-step sine lookup, so one tone period is 32 equal segments. The row and column samples are added into one signed word, clipped to the output width, and registered. The word feeds an external converter and filter.

Software-style controls choose whether the tone is on, whether one tone or both are sent, and which group a single tone comes from. They also select an automatic burst mode. In burst mode each accepted digit write produces one tone burst and then a silent pause of equal length, and a ready flag rises when the pause has ended. The nominal burst length is 51 ms at a 3.579545 MHz clock. In call-progress mode both the burst and the pause are twice as long. With burst mode off, the tone lasts exactly as long as the tone enable is high.

Top module: `dtmf_tone_gen`

## Requirements
- R1: The digit code selects the tone pair. Row 697 Hz is used by codes 1,2,3,13; row 770 Hz by 4,5,6,14; row 852 Hz by 7,8,9,15; row 941 Hz by 11,10,12,0. Column 1209 Hz is used by 1,4,7,11; column 1336 Hz by 2,5,8,10; column 1477 Hz by 3,6,9,12; column 1633 Hz by 13,14,15,0. (Here 10 is digit 0, 11 is star, 12 is hash, 13..15 are A..C, and 0 is D.)
- R2: A tone period is exactly 32 times its divider in clock cycles. The divider is round(CLK_HZ / (32 * f)).
- R3: Every generated frequency is within 0.75 % of its nominal value.
- R4: With singleTone high, only the row tone is sent when pickColumn is 0, and only the column tone when it is 1. The positive peak of a single tone equals ROW_AMP for a row tone and COL_AMP for a column tone.
- R5: In dual mode the output is the sum of both channel samples, clipped to the signed SAMPLE_W range. Its peak is above COL_AMP and at most ROW_AMP + COL_AMP.
- R6: While toneActive is low, sampleOut is 0 from the next cycle on. toneActive is never high while toneEnable is low.
- R7: With burstEnable high, a write accepted at a clock edge makes toneActive high (given toneEnable) for exactly BURST_CYCLES cycles. A pause of BURST_CYCLES cycles follows. txReady becomes visible 2*BURST_CYCLES+1 cycles after the write is driven.
- R8: txReady is 0 after reset. It is set only at the end of a pause, is cleared by an accepted write, and is held at 0 while burstEnable is low.
- R9: With callProgress high, the burst and the pause each last 2*BURST_CYCLES cycles.
- R10: A write during a burst or a pause is ignored: the digit, the tone period and the ready timing are unchanged. This includes a write in the final pause cycle.
- R11: With burstEnable low, toneActive follows toneEnable. Each tone starts from phase zero, so the first positive sample of a row-697 tone appears 161 cycles after enable.
- R12: After reset, sampleOut is 0 and both toneActive and txReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone clock (3.579545 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| txWrite | input | 1 | One-cycle strobe that writes txDigit |
| txDigit | input | 4 | Digit code to transmit |
| toneEnable | input | 1 | Tone output enable |
| burstEnable | input | 1 | Automatic burst/pause sequencing on |
| callProgress | input | 1 | Doubles burst and pause length |
| singleTone | input | 1 | Send one group only |
| pickColumn | input | 1 | In single mode: 1 column tone, 0 row tone |
| sampleOut | output | SAMPLE_W | Signed summed tone sample |
| toneActive | output | 1 | Tone currently being produced |
| txReady | output | 1 | Burst and pause finished, ready for next digit |

## Verification
The sequencer's pause completion and a fresh digit write can land on the same clock edge. The bench provokes this by timing a write so that it is sampled at the very edge that ends the pause. It then expects txReady to rise on schedule while toneActive stays low, which shows that the write was dropped rather than starting a new burst. A second overlap, a write in the middle of a burst, is judged by measuring the tone period that follows, which must keep the first digit's divider.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef struct packed {
    logic       toneOn;
    logic [1:0] rowSel;
    logic [1:0] colSel;
    logic       useRow;
    logic       useCol;
  } dtmf_ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_PAUSE} burst_state_e;

  function automatic logic [1:0] rowOf(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13:  rowOf = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14:  rowOf = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15:  rowOf = 2'd2;
      default:                  rowOf = 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] colOf(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11:  colOf = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10:  colOf = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12:  colOf = 2'd2;
      default:                  colOf = 2'd3;
    endcase
  endfunction

  function automatic int freqOf(input int isCol, input int sel);
    int f;
    if (isCol != 0) begin
      case (sel)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end else begin
      case (sel)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end
    return f;
  endfunction

  // rounded clock / (32 * f)
  function automatic int toneDiv(input int clkHz, input int hz);
    return (clkHz + 16 * hz) / (32 * hz);
  endfunction

  // quarter-wave sine, full scale 1024, index 0..8
  function automatic int quarterSine(input int q);
    int v;
    case (q)
      0: v = 0;
      1: v = 200;
      2: v = 392;
      3: v = 569;
      4: v = 724;
      5: v = 851;
      6: v = 946;
      7: v = 1004;
      default: v = 1024;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int IS_COL   = 0,
  parameter int AMP      = 800,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       run,
  input  logic [1:0]                 sel,
  output logic signed [SAMPLE_W-1:0] level
);

  localparam int DIV_0   = toneDiv(CLK_HZ, freqOf(IS_COL, 0));
  localparam int DIV_1   = toneDiv(CLK_HZ, freqOf(IS_COL, 1));
  localparam int DIV_2   = toneDiv(CLK_HZ, freqOf(IS_COL, 2));
  localparam int DIV_3   = toneDiv(CLK_HZ, freqOf(IS_COL, 3));
  localparam int DIV_W   = $clog2(DIV_0 + 1);
  localparam int PHASE_W = 5;

  logic [DIV_W-1:0]   divLimit;
  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] phase;
  logic               wrapNow;

  always_comb begin
    case (sel)
      2'd0:    divLimit = DIV_W'(DIV_0 - 1);
      2'd1:    divLimit = DIV_W'(DIV_1 - 1);
      2'd2:    divLimit = DIV_W'(DIV_2 - 1);
      default: divLimit = DIV_W'(DIV_3 - 1);
    endcase
  end

  assign wrapNow = (divCnt >= divLimit);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (wrapNow) begin
      divCnt <= '0;
      phase  <= phase + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  int magIdx;
  int scaled;

  always_comb begin
    magIdx = phase[3] ? (8 - int'(phase[2:0])) : int'(phase[2:0]);
    scaled = (quarterSine(magIdx) * AMP) >>> 10;
    level  = phase[4] ? SAMPLE_W'(-scaled) : SAMPLE_W'(scaled);
  end

endmodule

// File: rtl/dtmf_datapath.sv
module dtmf_datapath
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int SAMPLE_W = 12,
  parameter int ROW_AMP  = 800,
  parameter int COL_AMP  = 1007
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dtmf_ctrl_t                 ctrl,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int N_CHAN = 2;
  localparam int MAX_V  = (1 <<< (SAMPLE_W - 1)) - 1;
  localparam int MIN_V  = -(1 <<< (SAMPLE_W - 1));

  logic signed [SAMPLE_W-1:0] chanLevel [N_CHAN];
  logic                       chanUse   [N_CHAN];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    dtmf_tone_chan #(
      .CLK_HZ  (CLK_HZ),
      .IS_COL  (c),
      .AMP     ((c == 0) ? ROW_AMP : COL_AMP),
      .SAMPLE_W(SAMPLE_W)
    ) u_chan (
      .clk  (clk),
      .rstN (rstN),
      .run  (ctrl.toneOn),
      .sel  ((c == 0) ? ctrl.rowSel : ctrl.colSel),
      .level(chanLevel[c])
    );
    assign chanUse[c] = (c == 0) ? ctrl.useRow : ctrl.useCol;
  end

  int sumAll;
  int satVal;

  always_comb begin
    sumAll = 0;
    for (int c = 0; c < N_CHAN; c++) begin
      if (chanUse[c]) sumAll = sumAll + int'(chanLevel[c]);
    end
    if (sumAll > MAX_V)      satVal = MAX_V;
    else if (sumAll < MIN_V) satVal = MIN_V;
    else                     satVal = sumAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctrl.toneOn) sampleOut <= '0;
    else                       sampleOut <= SAMPLE_W'(satVal);
  end

endmodule

// File: rtl/dtmf_ctrl.sv
module dtmf_ctrl
  import dtmf_pkg::*;
#(
  parameter int BURST_CYCLES = 182557
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txWrite,
  input  logic [3:0] txDigit,
  input  logic       toneEnable,
  input  logic       burstEnable,
  input  logic       callProgress,
  input  logic       singleTone,
  input  logic       pickColumn,
  output dtmf_ctrl_t ctrl,
  output logic       toneActive,
  output logic       txReady
);

  localparam int CNT_W = $clog2(2 * BURST_CYCLES + 1);

  burst_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [3:0]       digit;
  logic             accept;
  logic             segDone;

  assign lastCnt = callProgress ? CNT_W'(2 * BURST_CYCLES - 1) : CNT_W'(BURST_CYCLES - 1);
  assign accept  = txWrite && (state == ST_IDLE);
  assign segDone = (cnt >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      digit   <= '0;
      txReady <= 1'b0;
    end else begin
      if (accept) digit <= txDigit;
      if (!burstEnable) begin
        state   <= ST_IDLE;
        cnt     <= '0;
        txReady <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (txWrite) begin
              state   <= ST_BURST;
              cnt     <= '0;
              txReady <= 1'b0;
            end
          end
          ST_BURST: begin
            if (segDone) begin
              state <= ST_PAUSE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAUSE: begin
            if (segDone) begin
              state   <= ST_IDLE;
              cnt     <= '0;
              txReady <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctrl.toneOn = toneEnable && (!burstEnable || (state == ST_BURST));
    ctrl.rowSel = rowOf(digit);
    ctrl.colSel = colOf(digit);
    ctrl.useRow = !singleTone || !pickColumn;
    ctrl.useCol = !singleTone || pickColumn;
  end

  assign toneActive = ctrl.toneOn;

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ       = 3579545,
  parameter int SAMPLE_W     = 12,
  parameter int ROW_AMP      = 800,
  parameter int COL_AMP      = 1007,
  parameter int BURST_MS     = 51,
  parameter int BURST_CYCLES = (CLK_HZ / 1000) * BURST_MS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txWrite,
  input  logic [3:0]                 txDigit,
  input  logic                       toneEnable,
  input  logic                       burstEnable,
  input  logic                       callProgress,
  input  logic                       singleTone,
  input  logic                       pickColumn,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       toneActive,
  output logic                       txReady
);

  dtmf_ctrl_t ctrl;

  dtmf_ctrl #(.BURST_CYCLES(BURST_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txWrite     (txWrite),
    .txDigit     (txDigit),
    .toneEnable  (toneEnable),
    .burstEnable (burstEnable),
    .callProgress(callProgress),
    .singleTone  (singleTone),
    .pickColumn  (pickColumn),
    .ctrl        (ctrl),
    .toneActive  (toneActive),
    .txReady     (txReady)
  );

  dtmf_datapath #(
    .CLK_HZ  (CLK_HZ),
    .SAMPLE_W(SAMPLE_W),
    .ROW_AMP (ROW_AMP),
    .COL_AMP (COL_AMP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sampleOut(sampleOut)
  );

endmodule

// File: rtl/dtmf_tone_gen_chk.sv
module dtmf_tone_gen_chk #(
  parameter int SAMPLE_W = 12,
  parameter int ROW_AMP  = 800
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       txWrite,
  input logic                       toneEnable,
  input logic                       burstEnable,
  input logic                       singleTone,
  input logic                       pickColumn,
  input logic signed [SAMPLE_W-1:0] sampleOut,
  input logic                       toneActive,
  input logic                       txReady
);

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !toneActive |=> (sampleOut == '0)); // R6

  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !toneEnable |-> !toneActive); // R6

  AST_READY_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    !burstEnable |=> !txReady); // R8

  AST_READY_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> ($past(!toneActive) && $past(burstEnable))); // R7

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && burstEnable && !txWrite) |=> txReady); // R8

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txWrite && burstEnable) |=> !txReady); // R8

  AST_NONBURST_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !burstEnable |-> (toneActive == toneEnable)); // R11

  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (singleTone && !pickColumn && $past(singleTone && !pickColumn))
      |-> (($signed(sampleOut) <= ROW_AMP) && ($signed(sampleOut) >= -ROW_AMP))); // R4

endmodule

bind dtmf_tone_gen dtmf_tone_gen_chk #(
  .SAMPLE_W(SAMPLE_W),
  .ROW_AMP (ROW_AMP)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txWrite    (txWrite),
  .toneEnable (toneEnable),
  .burstEnable(burstEnable),
  .singleTone (singleTone),
  .pickColumn (pickColumn),
  .sampleOut  (sampleOut),
  .toneActive (toneActive),
  .txReady    (txReady)
);

// File: tb/dtmf_tone_gen_test.sv
module dtmf_tone_gen_test;

  localparam int  CLK_PERIOD = 280;
  localparam int  CLK_HZ     = 3579545;
  localparam int  SAMPLE_W   = 12;
  localparam int  ROW_AMP    = 800;
  localparam int  COL_AMP    = 1007;
  localparam int  BURST_LEN  = 8000;
  localparam int  N_VEC      = 8;
  // digit code, column pick, nominal Hz
  localparam int  VECS [N_VEC][3] = '{
    '{1, 0, 697}, '{4, 0, 770}, '{7, 0, 852}, '{11, 0, 941},
    '{1, 1, 1209}, '{2, 1, 1336}, '{3, 1, 1477}, '{13, 1, 1633}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txWrite = 1'b0;
  logic [3:0] txDigit = 4'd0;
  logic toneEnable = 1'b0;
  logic burstEnable = 1'b0;
  logic callProgress = 1'b0;
  logic singleTone = 1'b0;
  logic pickColumn = 1'b0;
  logic signed [SAMPLE_W-1:0] sampleOut;
  logic toneActive;
  logic txReady;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  dtmf_tone_gen #(
    .CLK_HZ      (CLK_HZ),
    .SAMPLE_W    (SAMPLE_W),
    .ROW_AMP     (ROW_AMP),
    .COL_AMP     (COL_AMP),
    .BURST_CYCLES(BURST_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .txWrite(txWrite), .txDigit(txDigit),
    .toneEnable(toneEnable), .burstEnable(burstEnable), .callProgress(callProgress),
    .singleTone(singleTone), .pickColumn(pickColumn),
    .sampleOut(sampleOut), .toneActive(toneActive), .txReady(txReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  function automatic int expDiv(input int hz);
    return (CLK_HZ + 16 * hz) / (32 * hz);
  endfunction

  task automatic measurePeriod(output int per, output int pk);
    int first = -1;
    int prev = 0;
    int cur;
    per = -1;
    pk = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cur = int'(sampleOut);
      if (cur > pk) pk = cur;
      if (prev <= 0 && cur > 0) begin
        if (first < 0) first = i;
        else begin
          per = i - first;
          break;
        end
      end
      prev = cur;
    end
  endtask

  task automatic pulseWrite(input logic [3:0] d);
    txDigit = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 40000 && !txReady; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL R7 watchdog expired actual=%0d expected=finish", cycCnt);
    checkCnt++;
    failCnt++;
    finishRun();
  end

  initial begin
    int per, pk, hi, c0, n;
    real fHz, err;

    repeat (5) @(negedge clk);
    check(sampleOut == 0, "R12 sample after reset", int'(sampleOut), 0);
    check(!txReady, "R12 ready after reset", int'(txReady), 0);
    check(!toneActive, "R12 active after reset", int'(toneActive), 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table: single tones, period, accuracy and peak
    singleTone = 1'b1;
    for (int v = 0; v < N_VEC; v++) begin
      pickColumn = VECS[v][1][0];
      pulseWrite(4'(VECS[v][0]));
      toneEnable = 1'b1;
      measurePeriod(per, pk);
      check(per == 32 * expDiv(VECS[v][2]), "R1 R2 tone period", per, 32 * expDiv(VECS[v][2]));
      fHz = real'(CLK_HZ) / real'(per);
      err = (fHz - real'(VECS[v][2])) / real'(VECS[v][2]);
      if (err < 0.0) err = -err;
      check(err < 0.0075, "R3 frequency error (Hz)", int'(fHz), VECS[v][2]);
      check(pk == (VECS[v][1] != 0 ? COL_AMP : ROW_AMP), "R4 single-tone peak", pk,
            VECS[v][1] != 0 ? COL_AMP : ROW_AMP);
      toneEnable = 1'b0;
      @(negedge clk);
      check(!toneActive, "R6 active drops with enable", int'(toneActive), 0);
      @(negedge clk);
      check(sampleOut == 0, "R6 silent after disable", int'(sampleOut), 0);
    end

    // R11: tone starts from phase zero
    pickColumn = 1'b0;
    pulseWrite(4'd1);
    toneEnable = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (sampleOut > 0) break;
    end
    check(n == expDiv(697) + 1, "R11 first positive sample", n, expDiv(697) + 1);
    check(toneActive, "R11 active follows enable", int'(toneActive), 1);
    toneEnable = 1'b0;
    repeat (2) @(negedge clk);

    // R5: dual tone
    singleTone = 1'b0;
    pulseWrite(4'd5);
    toneEnable = 1'b1;
    pk = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (int'(sampleOut) > pk) pk = int'(sampleOut);
    end
    check(pk > COL_AMP && pk <= ROW_AMP + COL_AMP, "R5 dual peak", pk, ROW_AMP + COL_AMP);
    toneEnable = 1'b0;
    repeat (2) @(negedge clk);

    // R7 R8: normal burst
    singleTone = 1'b1;
    pickColumn = 1'b0;
    burstEnable = 1'b1;
    toneEnable = 1'b1;
    @(negedge clk);
    check(!toneActive && !txReady, "R8 idle burst mode", int'(txReady), 0);
    c0 = cycCnt;
    pulseWrite(4'd1);
    hi = 0;
    for (int i = 0; i < 40000 && toneActive; i++) begin
      hi++;
      @(negedge clk);
    end
    check(hi == BURST_LEN, "R7 burst length", hi, BURST_LEN);
    waitReady();
    check(cycCnt - c0 == 2 * BURST_LEN + 1, "R7 R8 ready after pause", cycCnt - c0, 2 * BURST_LEN + 1);

    // R8: accepted write clears ready
    pulseWrite(4'd2);
    check(!txReady, "R8 write clears ready", int'(txReady), 0);
    waitReady();

    // R10: mid-burst write ignored, and write in the final pause cycle ignored
    c0 = cycCnt;
    pulseWrite(4'd1);
    repeat (10) @(negedge clk);
    pulseWrite(4'd11);
    measurePeriod(per, pk);
    check(per == 32 * expDiv(697), "R10 digit kept during burst", per, 32 * expDiv(697));
    while (cycCnt < c0 + 2 * BURST_LEN) @(negedge clk);
    pulseWrite(4'd7);
    check(txReady && !toneActive, "R10 write at pause end dropped", int'(txReady), 1);
    check(cycCnt - c0 == 2 * BURST_LEN + 1, "R10 ready timing kept", cycCnt - c0, 2 * BURST_LEN + 1);
    @(negedge clk);
    check(txReady && !toneActive, "R10 no burst started", int'(toneActive), 0);

    // R9: call-progress doubles
    callProgress = 1'b1;
    c0 = cycCnt;
    pulseWrite(4'd3);
    hi = 0;
    for (int i = 0; i < 40000 && toneActive; i++) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 2 * BURST_LEN, "R9 doubled burst", hi, 2 * BURST_LEN);
    waitReady();
    check(cycCnt - c0 == 4 * BURST_LEN + 1, "R9 doubled pause", cycCnt - c0, 4 * BURST_LEN + 1);

    // R8: burst mode off clears ready
    burstEnable = 1'b0;
    @(negedge clk);
    check(!txReady, "R8 ready cleared without burst", int'(txReady), 0);
    check(toneActive, "R11 enable alone drives tone", int'(toneActive), 1);

    finishRun();
  end

endmodule